// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Collector

This block gathers 64 level-sensitive interrupt request lines and drives one interrupt line to a processor. Every source has a two-bit priority level, an enable bit and a software-trigger bit. Among the sources that are requesting and enabled, the block chooses one. It then offers the processor a vector address, formed from a programmable table base plus four times the number of the chosen source.

The block keeps one in-service bit per priority level. A level goes in service in one of two ways, chosen by a control bit: by a write to the vector register, or as a side effect of a read of it. The handler releases the level by writing that level's bit to the acknowledge register. Nesting can be on or off. When it is on, a new request is raised only if it sits strictly above every level still in service. When it is off, no request is raised while any level is in service.

Software reaches the block through a small 32-bit register bus with separate read and write strobes. Every register also appears at three alias addresses, which set, clear or toggle the written bits instead of replacing the whole register.

Top module: `irq_collector`

## Requirements
- R1: After reset, irq_out is low and every writable register reads zero. This covers control, vector base, scratchpad and all source-control registers. Status and vector also read zero.
- R2: Address bits 3:2 select the write operation on a register: 0 replaces its contents, 1 ORs the written bits in, 2 clears the written bits, 3 XORs them. Unimplemented bits read zero: control keeps only bits 16, 18 and 19, the vector base keeps only bits 31:2, and each source byte keeps only bits 3:0.
- R3: The control field of source n lives in register 0x060 + 0x10*(n>>2), at bit offset 8*(n&3). Within that byte, bits 1:0 are the priority, bit 2 is the enable and bit 3 is the software trigger.
- R4: A source is pending when it is enabled and either its line or its software trigger is high. irq_out can only be high while control bit 16 is set.
- R5: The selected source is a pending source of the highest priority. Among equal priorities, the lowest source number wins.
- R6: While a request is active, the vector register (0x000) reads base + 4*number and status (0x030) reads the number in bits 5:0. With no active request, the vector register reads the scratchpad (0x1F0) and status reads zero.
- R7: With control bit 18 clear, a write to the vector register puts the active request's level in service. A read of the vector register has no effect.
- R8: With control bit 18 set, a read of the vector register puts the active level in service. A write to the vector register has no effect.
- R9: With nesting on (control bit 19 clear), a request is active only if its level is strictly above every level in service.
- R10: With control bit 19 set, no request is active while any level is in service.
- R11: A write to the acknowledge register (0x010) releases every level whose bit among bits 3:0 is set.
- R12: Registers 0x040 and 0x050 read request lines 31:0 and 63:32. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src | input | 64 | Level-sensitive request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (vector-read side effect) |
| bus_addr | input | 9 | Byte address; bits 3:2 pick the write operation |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
First, each of the 64 sources is exercised alone. It is driven first by its line with the enable off, then with the enable on, then by its software trigger. These runs separate an error in the field layout from an error in the pending logic or in the vector arithmetic.

Next, pseudo-random line masks are applied with priorities spread over all 64 sources. Each mask is compared against a reference search that is computed arithmetically. This separates the highest-priority rule from the tie-break toward the lowest source number.

Scripted in-service sequences then run under both entry modes and with nesting on and off. They show the difference between an equal and a strictly higher level, and between partial and full acknowledgement.

// File: rtl/irq_collector.sv
module irq_collector #(
  parameter int NSRC = 64,
  parameter int AW   = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_src,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq_out
);
  localparam int NREG   = NSRC / 4;
  localparam int IDXW   = $clog2(NSRC);
  localparam int NLVL   = 4;
  localparam int RI_VEC = 0, RI_ACK = 1, RI_CTL = 2, RI_STAT = 3;
  localparam int RI_RAW0 = 4, RI_RAW1 = 5, RI_SRC0 = 6;
  localparam int RI_VBASE = RI_SRC0 + NREG;
  localparam int RI_SCR = 31;
  localparam logic [31:0] CTL_MASK = 32'h000D_0000;
  localparam logic [31:0] SRC_MASK = 32'h0F0F_0F0F;

  function automatic logic [31:0] upd(input logic [31:0] old, input logic [31:0] w,
                                      input logic [1:0] o);
    case (o)
      2'd0:    upd = w;
      2'd1:    upd = old | w;
      2'd2:    upd = old & ~w;
      default: upd = old ^ w;
    endcase
  endfunction

  logic [AW-5:0] ridx;
  logic [1:0]    op;
  assign ridx = bus_addr[AW-1:4];
  assign op   = bus_addr[3:2];

  logic [31:0] ctl_q, vbase_q, scr_q;
  logic [31:0] sctl_q [NREG];
  logic [NLVL-1:0] insvc_q;
  logic [63:0] raw;
  assign raw = 64'(irq_src);

  logic            glb_en, rse_mode, nest_off;
  assign glb_en   = ctl_q[16];
  assign rse_mode = ctl_q[18];
  assign nest_off = ctl_q[19];

  logic [NSRC-1:0] pend;
  logic [1:0]      prio [NSRC];
  generate
    for (genvar n = 0; n < NSRC; n++) begin : g_src
      logic [7:0] fld;
      assign fld     = sctl_q[n/4][8*(n%4) +: 8];
      assign prio[n] = fld[1:0];
      assign pend[n] = fld[2] & (irq_src[n] | fld[3]);
    end
  endgenerate

  logic            found;
  logic [IDXW-1:0] best;
  logic [1:0]      bprio;
  always_comb begin
    found = 1'b0;
    best  = '0;
    bprio = '0;
    for (int n = NSRC - 1; n >= 0; n--) begin
      if (pend[n] && (!found || prio[n] >= bprio)) begin
        found = 1'b1;
        best  = IDXW'(n);
        bprio = prio[n];
      end
    end
  end

  logic [1:0] top_lvl;
  always_comb begin
    top_lvl = '0;
    for (int l = 0; l < NLVL; l++)
      if (insvc_q[l]) top_lvl = 2'(l);
  end

  logic eligible, active, enter;
  assign eligible = (insvc_q == '0) || (!nest_off && bprio > top_lvl);
  assign active   = found && eligible;
  assign irq_out  = active && glb_en;

  logic [31:0] cur_vec;
  assign cur_vec = active ? ({vbase_q[31:2], 2'b00} + {30'(best), 2'b00}) : scr_q;

  assign enter = active && (ridx == RI_VEC) &&
                 ((!rse_mode && bus_wr) || (rse_mode && bus_rd));

  logic [NLVL-1:0] ack_clr;
  assign ack_clr = (bus_wr && ridx == RI_ACK) ? bus_wdata[NLVL-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) insvc_q <= '0;
    else        insvc_q <= (insvc_q & ~ack_clr) | (enter ? NLVL'(1) << bprio : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      vbase_q <= '0;
      scr_q   <= '0;
    end else if (bus_wr) begin
      if (ridx == RI_CTL)   ctl_q   <= upd(ctl_q, bus_wdata, op) & CTL_MASK;
      if (ridx == RI_VBASE) vbase_q <= upd(vbase_q, bus_wdata, op) & 32'hFFFF_FFFC;
      if (ridx == RI_SCR)   scr_q   <= upd(scr_q, bus_wdata, op);
    end
  end

  generate
    for (genvar k = 0; k < NREG; k++) begin : g_sreg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sctl_q[k] <= '0;
        else if (bus_wr && ridx == (AW-4)'(RI_SRC0 + k))
          sctl_q[k] <= upd(sctl_q[k], bus_wdata, op) & SRC_MASK;
      end
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (ridx == RI_VEC)        bus_rdata = cur_vec;
    else if (ridx == RI_CTL)   bus_rdata = ctl_q;
    else if (ridx == RI_STAT)  bus_rdata = active ? 32'(best) : '0;
    else if (ridx == RI_RAW0)  bus_rdata = raw[31:0];
    else if (ridx == RI_RAW1)  bus_rdata = raw[63:32];
    else if (ridx == RI_VBASE) bus_rdata = vbase_q;
    else if (ridx == RI_SCR)   bus_rdata = scr_q;
    else if (ridx >= RI_SRC0 && ridx < RI_VBASE)
      bus_rdata = sctl_q[ridx - (AW-4)'(RI_SRC0)];
  end
endmodule

// File: rtl/irq_collector_chk.sv
module irq_collector_chk #(
  parameter int NSRC = 64,
  parameter int AW   = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] irq_src,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [AW-1:0]   bus_addr,
  input logic [31:0]     bus_wdata,
  input logic [31:0]     bus_rdata,
  input logic            irq_out,
  input logic [31:0]     ctl_q,
  input logic [3:0]      insvc_q
);
  logic [AW-5:0] idx;
  assign idx = bus_addr[AW-1:4];

  // R4
  glb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ctl_q[16]);

  // R10
  no_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[19] && insvc_q != 4'b0) |-> !irq_out);

  // R11
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && idx == 1) |=> ((insvc_q & $past(bus_wdata[3:0])) == 4'b0));

  // R7
  rd_no_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && idx == 0 && !ctl_q[18]) |=> $stable(insvc_q));

  // R8
  wr_no_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && idx == 0 && ctl_q[18]) |=> $stable(insvc_q));

  // R12
  raw_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == 4) |-> (bus_rdata == irq_src[31:0]));
endmodule

bind irq_collector irq_collector_chk #(.NSRC(NSRC), .AW(AW)) u_chk (.*);

// File: tb/irq_collector_tb.sv
module irq_collector_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] irq_src = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  int          errors = 0, checks = 0;
  bit          done = 0;

  localparam logic [8:0] A_VEC = 9'h000, A_ACK = 9'h010, A_CTL = 9'h020, A_STAT = 9'h030;
  localparam logic [8:0] A_RAW0 = 9'h040, A_RAW1 = 9'h050, A_VBASE = 9'h160, A_SCR = 9'h1F0;

  always #5 clk = ~clk;

  irq_collector u_dut (.clk, .rst_n, .irq_src, .bus_wr, .bus_rd, .bus_addr,
                       .bus_wdata, .bus_rdata, .irq_out);

  function automatic logic [8:0] a_src(input int k);
    return 9'(9'h060 + 16 * k);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic peek(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic set_src(input logic [63:0] v);
    @(negedge clk); irq_src = v; #1;
  endtask

  task automatic clear_all();
    for (int k = 0; k < 16; k++) wr(a_src(k), 32'h0);
  endtask

  initial begin
    #(2_000_000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    #1 chk("R1 irq_out", 32'(irq_out), 0);
    peek(A_CTL, d);   chk("R1 ctl", d, 0);
    peek(A_VBASE, d); chk("R1 vbase", d, 0);
    peek(A_SCR, d);   chk("R1 scratch", d, 0);
    for (int k = 0; k < 16; k++) begin peek(a_src(k), d); chk("R1 src", d, 0); end
    peek(A_STAT, d);  chk("R1 status", d, 0);
    peek(A_VEC, d);   chk("R1 vector", d, 0);

    // R2 alias operations and masks
    wr(A_SCR, 32'hA5A5_0F0F);
    wr(A_SCR | 9'h4, 32'h0000_F000); peek(A_SCR, d); chk("R2 set", d, 32'hA5A5_FF0F);
    wr(A_SCR | 9'h8, 32'hA500_0000); peek(A_SCR, d); chk("R2 clear", d, 32'h00A5_FF0F);
    wr(A_SCR | 9'hC, 32'hFFFF_0000); peek(A_SCR, d); chk("R2 toggle", d, 32'hFF5A_FF0F);
    wr(A_VBASE, 32'h1234_5677); peek(A_VBASE, d); chk("R2 vbase mask", d, 32'h1234_5674);
    wr(A_CTL, 32'hFFFF_FFFF);   peek(A_CTL, d);   chk("R2 ctl mask", d, 32'h000D_0000);
    wr(a_src(3), 32'hFFFF_FFFF); peek(a_src(3), d); chk("R2 src mask", d, 32'h0F0F_0F0F);
    wr(a_src(3) | 9'h8, 32'h0F00_0000); peek(a_src(3), d); chk("R2 src clear", d, 32'h000F_0F0F);
    wr(a_src(3), 32'h0);

    // R12 raw view, writes ignored
    set_src(64'hDEAD_BEEF_0123_4567);
    peek(A_RAW0, d); chk("R12 raw0", d, 32'h0123_4567);
    peek(A_RAW1, d); chk("R12 raw1", d, 32'hDEAD_BEEF);
    wr(A_RAW0, 32'hFFFF_FFFF); wr(A_RAW1 | 9'h4, 32'h1);
    peek(A_RAW0, d); chk("R12 raw0 after write", d, 32'h0123_4567);
    peek(A_RAW1, d); chk("R12 raw1 after write", d, 32'hDEAD_BEEF);
    #1 chk("R12 irq idle", 32'(irq_out), 0);

    // R3/R4/R6 single-source sweep
    wr(A_CTL, 32'h0001_0000);
    wr(A_VBASE, 32'h0000_1000);
    for (int n = 0; n < 64; n++) begin
      set_src(64'd1 << n);
      chk("R4 line without enable", 32'(irq_out), 0);
      wr(a_src(n >> 2), 32'h4 << (8 * (n & 3)));
      #1 chk("R4 line enabled", 32'(irq_out), 1);
      peek(A_VEC, d);  chk("R6 vector", d, 32'h1000 + 4 * n);
      peek(A_STAT, d); chk("R3 status", d, 32'(n));
      wr(a_src(n >> 2), 32'h0);
    end
    set_src('0);
    for (int n = 0; n < 64; n++) begin
      wr(a_src(n >> 2), 32'hC << (8 * (n & 3)));
      #1 chk("R4 soft trigger", 32'(irq_out), 1);
      peek(A_STAT, d); chk("R3 soft status", d, 32'(n));
      wr(a_src(n >> 2), 32'h0);
    end
    wr(a_src(7), 32'h0C00_0000);
    wr(A_CTL, 32'h0);
    #1 chk("R4 global disable", 32'(irq_out), 0);
    peek(A_STAT, d); chk("R6 status without enable", d, 32'd31);
    wr(A_CTL, 32'h0001_0000);
    wr(a_src(7), 32'h0);

    // R5 arbitration sweep
    for (int t = 0; t < 24; t++) begin
      logic [63:0] m;
      int bp, bn;
      m = {32'h9E37_79B9 ^ 32'(t * 32'h0101_0101), 32'h7F4A_7C15 + 32'(t * 977)};
      m = m & ({64{1'b1}} >> (t % 5)) & ~(64'(t) << (t % 40));
      if (m == 0) m = 64'h1;
      for (int k = 0; k < 16; k++) begin
        logic [31:0] v = 0;
        for (int j = 0; j < 4; j++) begin
          int n = 4 * k + j;
          v |= 32'(4 | ((n * 3 + t * 7 + (n >> 2)) % 4)) << (8 * j);
        end
        wr(a_src(k), v);
      end
      set_src(m);
      bp = -1; bn = 0;
      for (int n = 0; n < 64; n++) begin
        int p = (n * 3 + t * 7 + (n >> 2)) % 4;
        if (m[n] && p > bp) begin bp = p; bn = n; end
      end
      #1 chk("R5 irq", 32'(irq_out), 1);
      peek(A_STAT, d); chk("R5 winner", d, 32'(bn));
    end
    set_src('0);
    clear_all();

    // R7/R9/R11 nesting with write entry
    wr(A_SCR, 32'hCAFE_0000);
    wr(a_src(1), 32'h0000_0500);
    set_src(64'h20);
    #1 chk("R7 src5 raised", 32'(irq_out), 1);
    rd(A_VEC, d); chk("R6 vector src5", d, 32'h1014);
    #1 chk("R7 read leaves request", 32'(irq_out), 1);
    wr(A_VEC, 32'h0);
    #1 chk("R9 equal level blocked", 32'(irq_out), 0);
    peek(A_VEC, d);  chk("R6 scratch when idle", d, 32'hCAFE_0000);
    peek(A_STAT, d); chk("R6 status when idle", d, 0);
    wr(a_src(2), 32'h0000_0600);
    set_src(64'h220);
    #1 chk("R9 higher level raises", 32'(irq_out), 1);
    peek(A_STAT, d); chk("R9 status src9", d, 9);
    wr(A_VEC, 32'h0);
    #1 chk("R7 write enters level 2", 32'(irq_out), 0);
    wr(a_src(0), 32'h0706_0000);
    set_src(64'h224);
    #1 chk("R9 equal level 2 blocked", 32'(irq_out), 0);
    set_src(64'h22C);
    #1 chk("R9 level 3 raises", 32'(irq_out), 1);
    peek(A_STAT, d); chk("R9 status src3", d, 3);
    set_src(64'h224);
    #1 chk("R9 level 3 gone", 32'(irq_out), 0);
    wr(A_ACK, 32'h4);
    #1 chk("R11 release level 2", 32'(irq_out), 1);
    peek(A_STAT, d); chk("R5 tie to src2", d, 2);
    wr(A_ACK, 32'h2);
    #1 chk("R11 release level 1", 32'(irq_out), 1);

    // R8 read entry
    wr(A_CTL, 32'h0005_0000);
    wr(A_VEC, 32'h0);
    #1 chk("R8 write ignored", 32'(irq_out), 1);
    rd(A_VEC, d); chk("R8 vector src2", d, 32'h1008);
    #1 chk("R8 read enters", 32'(irq_out), 0);
    wr(A_ACK | 9'h4, 32'hF);
    #1 chk("R11 release after read entry", 32'(irq_out), 1);

    // R10 nesting disabled
    wr(A_CTL, 32'h0009_0000);
    wr(A_VEC, 32'h0);
    #1 chk("R10 entered", 32'(irq_out), 0);
    set_src(64'h22C);
    #1 chk("R10 higher level held off", 32'(irq_out), 0);
    wr(A_ACK, 32'h4);
    #1 chk("R10 released", 32'(irq_out), 1);
    peek(A_STAT, d); chk("R10 status src3", d, 3);
    wr(A_CTL, 32'h0008_0000);
    #1 chk("R4 disable drops irq", 32'(irq_out), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule